// File: doc/BRIEF.md
# Register-Driven Half-Duplex Serial Flash Master

This block lets a processor talk to a serial flash through three registers on a simple memory-mapped bus. The bus has an address, write data, read data, one read strobe and one write strobe, and a ready handshake. Software sets the levels of two active-low chip-select pins directly through register bits. It also sets a transfer length of 1 to 4 bytes and picks a byte order for each direction. It then starts a transfer by accessing the data register. A write to the data register shifts the programmed bytes out on MOSI. A read of the data register shifts bytes in from MISO and stalls the bus until the word is complete.

Serial timing is SPI mode 0. SCLK idles low, MOSI changes only while SCLK is low, and MISO is sampled on each rising SCLK edge. The SCLK period is a parameterised even number of system clocks. Short transfers occupy the most significant byte lanes of the 32-bit data word. The byte-order bits choose whether the top used lane travels first or last on the wire. Each byte always goes MSB first.

Top module: `sflash_spi_host`

## Requirements
- R1: After reset, both chip-select pins are high and SCLK and MOSI are low. The control/status register reads 0xC800_0000 (both level bits 1, idle flag 1, length code 0, select 0) and the configuration register reads 0.
- R2: The register offsets are 0x0 for configuration, 0x8 for control/status and 0xC for data. Configuration bit 28 is the receive big-endian flag and bit 27 is the transmit big-endian flag. Control/status bits 31 and 30 are the pin levels for chip selects 0 and 1, bits 29:28 are the length code (n = code + 1 bytes), bit 27 is the read-only idle flag and bit 24 is the select bit. All other bits read as 0.
- R3: Chip-select pin 0 is low only when bit 31 is 0 and the select bit is 0. Pin 1 is low only when bit 30 is 0 and the select bit is 1. At most one pin is low at a time.
- R4: A data-register write while idle puts exactly 8n bits on MOSI. SCLK idles low and its period is CLK_DIV system clocks, and MOSI never changes while SCLK is high.
- R5: With the transmit big-endian flag set, lanes go out in the order 31:24, 23:16, and so on. With it clear, the n used top lanes go out in reverse order, starting with the lowest used lane. A 1-byte transmit takes bits 31:24 in both orders. Each byte is sent MSB first.
- R6: The idle flag reads 0 from the cycle after a transfer starts until the transfer ends. A data-register write made while a transfer runs is acknowledged and otherwise ignored: no extra bits are sent.
- R7: A data-register read holds bus ready low until 8n bits are captured, then returns the word with ready high for one cycle. Unused low lanes read as 0.
- R8: With the receive big-endian flag set, the first received byte lands in bits 31:24, the next in bits 23:16, and so on. With it clear, the lane order among the n used top lanes is reversed.
- R9: MOSI is held at 1 throughout a receive and is 0 while the shifter is idle.
- R10: Writes to any address, and reads of any address other than data, complete in the cycle they are presented. Unmapped offsets read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, held until ready |
| bus_wr | input | 1 | Write strobe, held until ready |
| bus_rdata | output | 32 | Read data, valid while ready is high |
| bus_ready | output | 1 | Access completes on a clock edge where this is high |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 2 | Active-low chip selects |

## Verification
The bench builds the block with CLK_DIV = 2. This is the smallest divisor, so the half-period counter reaches its limit every cycle and SCLK toggles on every clock. That setting is the hardest case for the MOSI-holds-while-high rule, and it keeps the 32-bit transfers short enough to sweep every length code in both byte orders. The default address width is kept, so the unmapped offsets between the three registers are reachable.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

  localparam int unsigned WORD_W = 32;

  localparam logic [3:0] OFS_CFG = 4'h0;
  localparam logic [3:0] OFS_CSR = 4'h8;
  localparam logic [3:0] OFS_DAT = 4'hC;

  // configuration register
  localparam int unsigned CFG_RX_BIG = 28;
  localparam int unsigned CFG_TX_BIG = 27;
  // control/status register
  localparam int unsigned CSR_CS0    = 31;
  localparam int unsigned CSR_CS1    = 30;
  localparam int unsigned CSR_LEN_HI = 29;
  localparam int unsigned CSR_LEN_LO = 28;
  localparam int unsigned CSR_IDLE   = 27;
  localparam int unsigned CSR_SEL    = 24;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_WAIT = 2'd1,
    BUS_DONE = 2'd2
  } bus_state_e;

  // Maps between lane form (lane 0 = bits 31:24) and wire order (slot 0 = first
  // byte on the wire), both using the top n lanes. The map is its own inverse.
  function automatic logic [WORD_W-1:0] lane_reorder(input logic [WORD_W-1:0] w,
                                                     input logic [2:0] n,
                                                     input logic big);
    logic [WORD_W-1:0] r;
    int src;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(n)) begin
        src = big ? i : int'(n) - 1 - i;
        r[8*(3-i) +: 8] = w[8*(3-src) +: 8];
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/sflash_rst_sync.sv
module sflash_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/sflash_sclk_gen.sv
module sflash_sclk_gen #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned HALF   = CLK_DIV / 2;
  localparam int unsigned HCNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HCNT_W-1:0] HLAST = HCNT_W'(HALF - 1);

  logic [HCNT_W-1:0] hcnt_q, hcnt_d;

  assign tick = run && (hcnt_q == HLAST);

  always_comb begin
    hcnt_d = hcnt_q;
    if (!run)      hcnt_d = '0;
    else if (tick) hcnt_d = '0;
    else           hcnt_d = hcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt_q <= '0;
    else        hcnt_q <= hcnt_d;
  end
endmodule

// File: rtl/sflash_shifter.sv
module sflash_shifter
  import sflash_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_tx,
  input  logic              start_rx,
  input  logic [1:0]        len_code,
  input  logic              tx_big,
  input  logic              rx_big,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  output logic              active,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);
  logic              active_q, active_d;
  logic              sclk_q, sclk_d;
  logic              txmode_q, txmode_d;
  logic              rxbig_q, rxbig_d;
  logic [2:0]        nbyte_q, nbyte_d;
  logic [4:0]        bitcnt_q, bitcnt_d;
  logic [WORD_W-1:0] txsr_q, txsr_d;
  logic [WORD_W-1:0] rxsr_q, rxsr_d;
  logic [WORD_W-1:0] rxw_q, rxw_d;
  logic              tick;
  logic              last_bit;
  logic [2:0]        start_n;
  logic [5:0]        rx_align;

  sflash_sclk_gen #(.CLK_DIV(CLK_DIV)) u_sclk_gen (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (active_q),
    .tick (tick)
  );

  assign start_n  = {1'b0, len_code} + 3'd1;
  assign last_bit = (bitcnt_q == 5'({nbyte_q, 3'b000} - 6'd1));
  assign rx_align = 6'd32 - {nbyte_q, 3'b000};

  always_comb begin
    active_d = active_q;
    sclk_d   = sclk_q;
    txmode_d = txmode_q;
    rxbig_d  = rxbig_q;
    nbyte_d  = nbyte_q;
    bitcnt_d = bitcnt_q;
    txsr_d   = txsr_q;
    rxsr_d   = rxsr_q;
    rxw_d    = rxw_q;
    done     = 1'b0;
    if (!active_q) begin
      if (start_tx || start_rx) begin
        active_d = 1'b1;
        sclk_d   = 1'b0;
        bitcnt_d = '0;
        nbyte_d  = start_n;
        txmode_d = start_tx;
        rxbig_d  = rx_big;
        rxsr_d   = '0;
        txsr_d   = start_tx ? lane_reorder(tx_word, start_n, tx_big) : '1;
      end
    end else if (tick) begin
      if (!sclk_q) begin
        sclk_d = 1'b1;
        if (!txmode_q) rxsr_d = {rxsr_q[WORD_W-2:0], miso};
      end else begin
        sclk_d = 1'b0;
        if (last_bit) begin
          active_d = 1'b0;
          done     = 1'b1;
          if (!txmode_q) rxw_d = lane_reorder(rxsr_q << rx_align, nbyte_q, rxbig_q);
        end else begin
          bitcnt_d = bitcnt_q + 5'd1;
          if (txmode_q) txsr_d = {txsr_q[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      txmode_q <= 1'b0;
      rxbig_q  <= 1'b0;
      nbyte_q  <= 3'd1;
      bitcnt_q <= '0;
      txsr_q   <= '0;
      rxsr_q   <= '0;
      rxw_q    <= '0;
    end else begin
      active_q <= active_d;
      sclk_q   <= sclk_d;
      txmode_q <= txmode_d;
      rxbig_q  <= rxbig_d;
      nbyte_q  <= nbyte_d;
      bitcnt_q <= bitcnt_d;
      txsr_q   <= txsr_d;
      rxsr_q   <= rxsr_d;
      rxw_q    <= rxw_d;
    end
  end

  assign active  = active_q;
  assign sclk    = sclk_q;
  assign mosi    = active_q & txsr_q[WORD_W-1];
  assign rx_word = rxw_q;
endmodule

// File: rtl/sflash_regs.sv
module sflash_regs
  import sflash_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_ready,
  input  logic              busy,
  input  logic              done,
  input  logic [WORD_W-1:0] rx_word,
  output logic              start_tx,
  output logic              start_rx,
  output logic [1:0]        len_code,
  output logic              tx_big,
  output logic              rx_big,
  output logic [1:0]        cs_n
);
  logic        hit_cfg, hit_csr, hit_dat;
  logic        cfg_we, csr_we;
  logic        rxbig_q, txbig_q;
  logic        cs0_q, cs1_q, sel_q;
  logic [1:0]  len_q;
  bus_state_e  st_q, st_d;

  assign hit_cfg = (bus_addr == ADDR_W'(OFS_CFG));
  assign hit_csr = (bus_addr == ADDR_W'(OFS_CSR));
  assign hit_dat = (bus_addr == ADDR_W'(OFS_DAT));
  assign cfg_we  = bus_wr && hit_cfg;
  assign csr_we  = bus_wr && hit_csr;

  // receive sequencing on data-register reads
  always_comb begin
    st_d     = st_q;
    start_rx = 1'b0;
    case (st_q)
      BUS_IDLE: if (bus_rd && hit_dat && !busy) begin
        start_rx = 1'b1;
        st_d     = BUS_WAIT;
      end
      BUS_WAIT: if (done) st_d = BUS_DONE;
      BUS_DONE: st_d = BUS_IDLE;
      default:  st_d = BUS_IDLE;
    endcase
  end

  assign start_tx  = bus_wr && hit_dat && !busy && (st_q == BUS_IDLE);
  assign bus_ready = !(bus_rd && hit_dat) || (st_q == BUS_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= BUS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxbig_q <= 1'b0;
      txbig_q <= 1'b0;
    end else if (cfg_we) begin
      rxbig_q <= bus_wdata[CFG_RX_BIG];
      txbig_q <= bus_wdata[CFG_TX_BIG];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs0_q <= 1'b1;
      cs1_q <= 1'b1;
      len_q <= 2'd0;
      sel_q <= 1'b0;
    end else if (csr_we) begin
      cs0_q <= bus_wdata[CSR_CS0];
      cs1_q <= bus_wdata[CSR_CS1];
      len_q <= bus_wdata[CSR_LEN_HI:CSR_LEN_LO];
      sel_q <= bus_wdata[CSR_SEL];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_cfg) begin
      bus_rdata[CFG_RX_BIG] = rxbig_q;
      bus_rdata[CFG_TX_BIG] = txbig_q;
    end else if (hit_csr) begin
      bus_rdata[CSR_CS0]               = cs0_q;
      bus_rdata[CSR_CS1]               = cs1_q;
      bus_rdata[CSR_LEN_HI:CSR_LEN_LO] = len_q;
      bus_rdata[CSR_IDLE]              = !busy;
      bus_rdata[CSR_SEL]               = sel_q;
    end else if (hit_dat) begin
      bus_rdata = rx_word;
    end
  end

  assign len_code = len_q;
  assign tx_big   = txbig_q;
  assign rx_big   = rxbig_q;
  assign cs_n[0]  = cs0_q | sel_q;
  assign cs_n[1]  = cs1_q | ~sel_q;
endmodule

// File: rtl/sflash_spi_host.sv
module sflash_spi_host
  import sflash_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [1:0]        spi_cs_n
);
  logic              rst_sync_n;
  logic              xfer_busy;
  logic              xfer_done;
  logic              start_tx, start_rx;
  logic [1:0]        len_code;
  logic              tx_big, rx_big;
  logic [WORD_W-1:0] rx_word;

  sflash_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  sflash_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_rdata(bus_rdata),
    .bus_ready(bus_ready),
    .busy     (xfer_busy),
    .done     (xfer_done),
    .rx_word  (rx_word),
    .start_tx (start_tx),
    .start_rx (start_rx),
    .len_code (len_code),
    .tx_big   (tx_big),
    .rx_big   (rx_big),
    .cs_n     (spi_cs_n)
  );

  sflash_shifter #(.CLK_DIV(CLK_DIV)) u_shifter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_tx(start_tx),
    .start_rx(start_rx),
    .len_code(len_code),
    .tx_big  (tx_big),
    .rx_big  (rx_big),
    .tx_word (bus_wdata),
    .miso    (spi_miso),
    .active  (xfer_busy),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .done    (xfer_done),
    .rx_word (rx_word)
  );
endmodule

// File: rtl/sflash_spi_host_chk.sv
module sflash_spi_host_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_ready,
  input logic              busy,
  input logic              spi_sclk,
  input logic              spi_mosi,
  input logic [1:0]        spi_cs_n
);
  localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(4'hC);

  a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk);

  a_r4_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));

  a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  a_r6_write_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == DAT_ADDR) && !busy) |=> busy);

  a_r10_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> bus_ready);

  a_r9_mosi_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_mosi);
endmodule

bind sflash_spi_host sflash_spi_host_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_ready(bus_ready),
  .busy     (xfer_busy),
  .spi_sclk (spi_sclk),
  .spi_mosi (spi_mosi),
  .spi_cs_n (spi_cs_n)
);

// File: tb/sflash_spi_host_test.sv
`timescale 1ns/1ps
module sflash_spi_host_test;
  localparam int DIV = 2;
  localparam realtime TCK = 20.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [1:0]  spi_cs_n;

  int total = 0;
  int bad = 0;

  logic [31:0] miso_pat = '0;
  logic        mon_en = 1'b0;
  logic [31:0] mon_sr = '0;
  int          mon_cnt = 0;
  int          per_bad = 0;
  int          glitch = 0;
  realtime     last_rise = 0;

  always #(TCK/2) clk = ~clk;

  sflash_spi_host #(.ADDR_W(4), .CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // flash model
  assign spi_miso = miso_pat[31];
  always @(negedge spi_sclk) miso_pat <= {miso_pat[30:0], 1'b0};
  always @(posedge spi_sclk) begin
    if (mon_en) begin
      mon_sr  <= {mon_sr[30:0], spi_mosi};
      mon_cnt <= mon_cnt + 1;
      if (last_rise > 0 && ($realtime - last_rise) != DIV * TCK) per_bad <= per_bad + 1;
      last_rise <= $realtime;
    end
  end
  always @(spi_mosi) if (spi_sclk === 1'b1) glitch <= glitch + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d, output int waits);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; waits = 0;
    #1;
    while (!bus_ready && waits < 5000) begin
      @(negedge clk); #1; waits++;
    end
    d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic mon_clear();
    mon_sr = '0; mon_cnt = 0; per_bad = 0; glitch = 0; last_rise = 0; mon_en = 1'b1;
  endtask

  task automatic wait_idle(output logic [31:0] first);
    logic [31:0] v; int w; int n;
    bus_read(4'h8, first, w);
    v = first; n = 0;
    while (!v[27] && n < 2000) begin bus_read(4'h8, v, w); n++; end
  endtask

  function automatic logic [31:0] csr_val(input bit cs0, input bit cs1, input logic [1:0] len, input bit sel);
    return {cs0, cs1, len, 1'b0, 2'b00, sel, 24'h0};
  endfunction

  task automatic test_reset();
    logic [31:0] d; int w;
    check(spi_cs_n == 2'b11, "R1 cs pins", {30'b0, spi_cs_n}, 32'h3);
    check(spi_sclk == 1'b0 && spi_mosi == 1'b0, "R1 sclk/mosi low", {30'b0, spi_sclk, spi_mosi}, 32'h0);
    bus_read(4'h8, d, w);
    check(d == 32'hC800_0000, "R1 csr reset", d, 32'hC800_0000);
    bus_read(4'h0, d, w);
    check(d == 32'h0, "R1 cfg reset", d, 32'h0);
  endtask

  task automatic test_regs();
    logic [31:0] d; int w;
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_read(4'h0, d, w);
    check(d == 32'h1800_0000, "R2 cfg fields", d, 32'h1800_0000);
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_read(4'h8, d, w);
    check(d == 32'hF900_0000, "R2 csr fields", d, 32'hF900_0000);
    bus_write(4'h8, 32'h0000_0000);
    bus_read(4'h8, d, w);
    check(d == 32'h0800_0000, "R2 idle flag read-only", d, 32'h0800_0000);
    bus_write(4'h0, 32'h0);
    bus_write(4'h8, csr_val(1, 1, 2'd0, 0));
  endtask

  task automatic test_cs();
    bus_write(4'h8, csr_val(0, 0, 2'd0, 0));
    #1 check(spi_cs_n == 2'b10, "R3 select 0", {30'b0, spi_cs_n}, 32'h2);
    bus_write(4'h8, csr_val(0, 0, 2'd0, 1));
    #1 check(spi_cs_n == 2'b01, "R3 select 1", {30'b0, spi_cs_n}, 32'h1);
    bus_write(4'h8, csr_val(1, 0, 2'd0, 0));
    #1 check(spi_cs_n == 2'b11, "R3 level high on selected pin", {30'b0, spi_cs_n}, 32'h3);
    bus_write(4'h8, csr_val(1, 1, 2'd0, 0));
  endtask

  task automatic test_tx(input bit big, input logic [1:0] len, input logic [31:0] word, input bit busy_write);
    logic [31:0] first, expv; int n, lane;
    n = int'(len) + 1;
    expv = '0;
    for (int i = 0; i < n; i++) begin
      lane = big ? i : n - 1 - i;
      expv = (expv << 8) | 32'(word[8*(3-lane) +: 8]);
    end
    bus_write(4'h0, big ? 32'h0800_0000 : 32'h0);
    bus_write(4'h8, csr_val(0, 1, len, 0));
    mon_clear();
    bus_write(4'hC, word);
    if (busy_write) bus_write(4'hC, ~word);
    wait_idle(first);
    repeat (4) @(negedge clk);
    mon_en = 1'b0;
    check(first[27] == 1'b0, "R6 idle flag low while busy", {31'b0, first[27]}, 32'h0);
    check(mon_cnt == 8 * n, "R4 bit count", 32'(mon_cnt), 32'(8 * n));
    check((n == 4 ? mon_sr : (mon_sr & ((32'h1 << (8 * n)) - 1))) == expv, "R5 wire order", mon_sr, expv);
    check(per_bad == 0, "R4 sclk period", 32'(per_bad), 32'h0);
    check(glitch == 0, "R4 mosi stable while sclk high", 32'(glitch), 32'h0);
    bus_write(4'h8, csr_val(1, 1, 2'd0, 0));
  endtask

  task automatic test_rx(input bit big, input logic [1:0] len, input logic [31:0] pat);
    logic [31:0] d, expv, ones; int n, w, src;
    n = int'(len) + 1;
    expv = '0;
    for (int l = 0; l < n; l++) begin
      src = big ? l : n - 1 - l;
      expv[8*(3-l) +: 8] = pat[8*(3-src) +: 8];
    end
    ones = (n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 1);
    bus_write(4'h0, big ? 32'h1000_0000 : 32'h0);
    bus_write(4'h8, csr_val(0, 1, len, 0));
    miso_pat = pat;
    mon_clear();
    bus_read(4'hC, d, w);
    repeat (4) @(negedge clk);
    mon_en = 1'b0;
    check(d == expv, big ? "R8 big-endian receive word" : "R8 little-endian receive word", d, expv);
    check(w >= 8 * n * DIV, "R7 ready held low", 32'(w), 32'(8 * n * DIV));
    check(mon_cnt == 8 * n, "R7 bits captured", 32'(mon_cnt), 32'(8 * n));
    check((mon_sr & ones) == ones, "R9 mosi high during receive", mon_sr & ones, ones);
    bus_write(4'h8, csr_val(1, 1, 2'd0, 0));
  endtask

  task automatic test_unmapped();
    logic [31:0] d; int w;
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_read(4'h4, d, w);
    check(d == 32'h0, "R10 unmapped reads zero", d, 32'h0);
    check(w == 0, "R10 no wait on register read", 32'(w), 32'h0);
    bus_read(4'h8, d, w);
    check(d == 32'hC800_0000, "R10 unmapped write ignored", d, 32'hC800_0000);
  endtask

  initial begin
    #(TCK * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_regs();
    test_cs();
    test_tx(1'b1, 2'd3, 32'hA1B2_C3D4, 1'b0);
    test_tx(1'b0, 2'd3, 32'hA1B2_C3D4, 1'b0);
    test_tx(1'b1, 2'd0, 32'h5A12_3456, 1'b0);
    test_tx(1'b0, 2'd0, 32'h6B00_00FF, 1'b0);
    test_tx(1'b0, 2'd2, 32'h1122_3344, 1'b0);
    test_tx(1'b1, 2'd1, 32'h9876_5432, 1'b1); // R6 write while busy ignored
    test_rx(1'b1, 2'd3, 32'hDEAD_BEEF);
    test_rx(1'b0, 2'd3, 32'hDEAD_BEEF);
    test_rx(1'b1, 2'd1, 32'hCAFE_1234);
    test_rx(1'b0, 2'd2, 32'h1234_5678);
    test_rx(1'b0, 2'd0, 32'h8100_0000);
    test_unmapped();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule